// File: doc/BRIEF.md
# Delayed Reset Controller with Warning Interrupt

This block sits between the chip's reset sources and the system reset line. Each source (loss of clock, loss of PLL lock, watchdog, external reset pin, core lockup, software request, stop-acknowledge error, second core) can be marked as "warned". When a warned source fires, the controller first raises an interrupt. It then holds off the system reset for a programmable number of low-power clock cycles, which gives software a window to shut down cleanly. A source that is not warned, or any source while the global enable is clear, resets the system at once and raises no interrupt.

The whole block runs on the low-power clock. It is configured by writing one register word. The two lowest bits hold the delay code, bit 2 holds the global enable, and the bits above hold one enable per source. Once the system reset is raised it stays raised until the block's own reset (`rst_n`) is applied. In a chip, that reset comes from the system reset itself.

The control is a four-state machine:
- `ST_IDLE` waits for a request.
- `ST_WARN` is the counting window, with the interrupt raised.
- `ST_RST_WARNED` asserts reset after a warning.
- `ST_RST_DIRECT` asserts reset with no warning.

Its transitions are:
- *warn_start*: `ST_IDLE` to `ST_WARN`, on a warned request.
- *direct_hit*: `ST_IDLE` to `ST_RST_DIRECT`, on an unwarned request.
- *expire*: `ST_WARN` to `ST_RST_WARNED`, when the counter reaches zero.
- *escalate*: `ST_WARN` to `ST_RST_WARNED`, when an unwarned request arrives during the window.
- *hold*: both reset states loop on themselves.

Top module: `rst_dly_ctrl`

## Requirements
- R1: After `rst_n`, `warn_irq` and `sys_rst_req` are 0, and the configuration word is all zero. With that zero configuration, any request resets the system directly.
- R2: A write (`cfg_wr`=1) loads `cfg_wdata` on the next clock edge. Bits [1:0] are the delay code, bit 2 is the global enable, and bit 3+i enables the warning for source i. The source order is 0 clock loss, 1 lock loss, 2 watchdog, 3 pin, 4 lockup, 5 software, 6 stop-ack error, 7 second core.
- R3: Delay code c gives a window of N = 8·4^c cycles: 8, 32, 128 or 512. `sys_rst_req` rises exactly N clock cycles after `warn_irq` rises.
- R4: A request on a source whose enable bit is set, while the global enable is set, raises `warn_irq` in the cycle after the request is sampled. In that cycle `sys_rst_req` is still 0.
- R5: A request on a source whose enable bit is clear, or on any source while the global enable is clear, raises `sys_rst_req` in the cycle after it is sampled. `warn_irq` stays 0 in that case.
- R6: Further warned requests during the window do not restart or extend the count.
- R7: An unwarned request during the window raises `sys_rst_req` in the next cycle, and `warn_irq` stays 1.
- R8: Once raised, `warn_irq` stays 1 through the reset until `rst_n` is applied.
- R9: Once raised, `sys_rst_req` stays 1 until `rst_n` is applied.
- R10: Writing a new delay code while the window runs does not change the length of the running window.
- R11: A one-cycle request pulse is enough to start either path. With no request, both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lp | input | 1 | Low-power clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | NSRC+3 | Configuration word: delay code, global enable, per-source enables |
| src_req | input | NSRC | Per-source reset requests, sampled every cycle |
| warn_irq | output | 1 | Warning interrupt ahead of a delayed reset |
| sys_rst_req | output | 1 | System reset request |

## Verification
The bench measures the window length for every delay code down to the exact cycle. A counter that is off by one, or that decodes the code wrongly, would give a window one cycle too long or short, or the wrong length altogether.

It injects extra requests inside a running window:
- A warned request would expose a design that reloads the counter, because the reset would come late.
- An unwarned request would expose a design that ignores the escalation, because the reset would wait for the window to run out.

It also rewrites the delay code in mid-window and mixes the global enable with partial masks. A design that samples the code late would change the window length. A design that ignores the global enable would raise a spurious interrupt instead of resetting at once.

// File: rtl/rst_dly_pkg.sv
package rst_dly_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WARN       = 2'd1,
        ST_RST_WARNED = 2'd2,
        ST_RST_DIRECT = 2'd3
    } rd_state_e;

    // Window length for a delay code: base scaled by 2^(step*code)
    function automatic int unsigned window_len(input int unsigned code,
                                               input int unsigned base,
                                               input int unsigned step);
        return base << (step * code);
    endfunction

endpackage

// File: rtl/rst_dly_cfg.sv
module rst_dly_cfg #(
    parameter int NSRC   = 8,
    parameter int CODE_W = 2,
    localparam int CFG_W = NSRC + CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CODE_W-1:0] dly_code,
    output logic              glb_en,
    output logic [NSRC-1:0]   src_en
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= wdata;
        end
    end

    assign dly_code = cfg_q[CODE_W-1:0];
    assign glb_en   = cfg_q[CODE_W];
    assign src_en   = cfg_q[CFG_W-1:CODE_W+1];

endmodule

// File: rtl/rst_dly_classify.sv
module rst_dly_classify #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] src_en,
    input  logic            glb_en,
    output logic            warn_hit,
    output logic            direct_hit
);

    logic [NSRC-1:0] warned;
    logic [NSRC-1:0] direct;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign warned[i] = req[i] &  (src_en[i] & glb_en);
        assign direct[i] = req[i] & ~(src_en[i] & glb_en);
    end

    assign warn_hit   = |warned;
    assign direct_hit = |direct;

endmodule

// File: rtl/rst_dly_timer.sv
module rst_dly_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: a running window counts down by exactly one per cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: a running window is never reloaded
    a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !load);

endmodule

// File: rtl/rst_dly_ctrl.sv
module rst_dly_ctrl
    import rst_dly_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int CODE_W   = 2,
    parameter int BASE_DLY = 8,
    parameter int DLY_STEP = 2,
    localparam int CFG_W   = NSRC + CODE_W + 1,
    localparam int MAX_DLY = BASE_DLY << (DLY_STEP * ((1 << CODE_W) - 1)),
    localparam int CNT_W   = $clog2(MAX_DLY)
) (
    input  logic             clk_lp,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NSRC-1:0]  src_req,
    output logic             warn_irq,
    output logic             sys_rst_req
);

    logic [CODE_W-1:0] dly_code;
    logic              glb_en;
    logic [NSRC-1:0]   src_en;
    logic              warn_hit;
    logic              direct_hit;
    logic              tmr_load;
    logic              tmr_run;
    logic              tmr_expired;
    logic [CNT_W-1:0]  tmr_load_val;
    rd_state_e         state_q;
    rd_state_e         state_d;

    rst_dly_cfg #(.NSRC(NSRC), .CODE_W(CODE_W)) u_cfg (
        .clk      (clk_lp),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .dly_code (dly_code),
        .glb_en   (glb_en),
        .src_en   (src_en)
    );

    rst_dly_classify #(.NSRC(NSRC)) u_classify (
        .req        (src_req),
        .src_en     (src_en),
        .glb_en     (glb_en),
        .warn_hit   (warn_hit),
        .direct_hit (direct_hit)
    );

    assign tmr_load_val = CNT_W'(window_len(32'(dly_code), BASE_DLY, DLY_STEP) - 1);
    assign tmr_load     = (state_q == ST_IDLE) && warn_hit && !direct_hit;
    assign tmr_run      = (state_q == ST_WARN);

    rst_dly_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk_lp),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_load_val),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk_lp or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (direct_hit) begin
                    state_d = ST_RST_DIRECT;   // direct_hit
                end else if (warn_hit) begin
                    state_d = ST_WARN;         // warn_start
                end
            end
            ST_WARN: begin
                if (direct_hit || tmr_expired) begin
                    state_d = ST_RST_WARNED;   // escalate / expire
                end
            end
            ST_RST_WARNED: state_d = ST_RST_WARNED;  // hold
            ST_RST_DIRECT: state_d = ST_RST_DIRECT;  // hold
            default:       state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        warn_irq    = 1'b0;
        sys_rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WARN: warn_irq = 1'b1;
            ST_RST_WARNED: begin
                warn_irq    = 1'b1;
                sys_rst_req = 1'b1;
            end
            ST_RST_DIRECT: sys_rst_req = 1'b1;
            default: ;
        endcase
    end

    // R5: unwarned request from idle resets next cycle with no interrupt
    a_r5_direct_no_irq: assert property (@(posedge clk_lp) disable iff (!rst_n)
        (state_q == ST_IDLE && direct_hit) |=> (sys_rst_req && !warn_irq));

    // R7: unwarned request during the window escalates at once
    a_r7_escalate: assert property (@(posedge clk_lp) disable iff (!rst_n)
        (state_q == ST_WARN && direct_hit) |=> (sys_rst_req && warn_irq));

    // R9: reset holds until block reset
    a_r9_reset_hold: assert property (@(posedge clk_lp) disable iff (!rst_n)
        sys_rst_req |=> sys_rst_req);

    // R8: interrupt holds until block reset
    a_r8_irq_hold: assert property (@(posedge clk_lp) disable iff (!rst_n)
        warn_irq |=> warn_irq);

    // R4: a warned reset is always preceded by the window
    a_r4_warn_first: assert property (@(posedge clk_lp) disable iff (!rst_n)
        ($rose(sys_rst_req) && warn_irq) |-> ($past(state_q) == ST_WARN));

endmodule

// File: tb/rst_dly_ctrl_bench.sv
module rst_dly_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int CFG_W = NSRC + 3;

    logic             clk_lp = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [NSRC-1:0]  src_req = '0;
    logic             warn_irq;
    logic             sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    rst_dly_ctrl u_rst_dly_ctrl (
        .clk_lp      (clk_lp),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .src_req     (src_req),
        .warn_irq    (warn_irq),
        .sys_rst_req (sys_rst_req)
    );

    always #(CLK_PERIOD/2) clk_lp = ~clk_lp;

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL all: watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic int exp_len(input logic [1:0] code);
        return 8 << (2 * code);
    endfunction

    function automatic logic is_direct(input logic [CFG_W-1:0] cfg, input logic [NSRC-1:0] req);
        logic [NSRC-1:0] en;
        en = cfg[2] ? cfg[CFG_W-1:3] : '0;
        return |(req & ~en);
    endfunction

    function automatic logic [CFG_W-1:0] mk_cfg(input logic [NSRC-1:0] en, input logic g, input logic [1:0] code);
        return {en, g, code};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_lp);
        rst_n = 1'b0; cfg_wr = 1'b0; src_req = '0;
        repeat (2) @(negedge clk_lp);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk_lp); @(negedge clk_lp);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] r);
        src_req = r;
        @(posedge clk_lp); @(negedge clk_lp);
        src_req = '0;
    endtask

    // One full scenario. extra_at < 0 means no extra request in the window.
    task automatic trial(input logic [CFG_W-1:0] cfg, input logic [NSRC-1:0] req,
                         input logic [NSRC-1:0] extra, input int extra_at,
                         input int new_code_at);
        int n;
        int exp_cyc;
        int c;
        do_reset();
        write_cfg(cfg);
        pulse(req);
        if (is_direct(cfg, req)) begin
            check("R5 direct rst", int'(sys_rst_req), 1);
            check("R5 direct irq", int'(warn_irq), 0);
            repeat (3) @(negedge clk_lp);
            check("R9 rst held", int'(sys_rst_req), 1);
        end else begin
            check("R4 irq raised", int'(warn_irq), 1);
            check("R4 rst low", int'(sys_rst_req), 0);
            n = exp_len(cfg[1:0]);
            exp_cyc = n;
            if (extra_at >= 0 && extra_at < n && is_direct(cfg, extra))
                exp_cyc = extra_at + 1;
            c = 0;
            while (sys_rst_req == 1'b0 && c < 700) begin
                if (c == extra_at) src_req = extra;
                if (c == new_code_at) begin
                    cfg_wr = 1'b1;
                    cfg_wdata = {cfg[CFG_W-1:2], ~cfg[1:0]};
                end
                @(posedge clk_lp); @(negedge clk_lp);
                src_req = '0; cfg_wr = 1'b0;
                c++;
            end
            if (extra_at >= 0 && exp_cyc != n)
                check("R7 escalate cycle", c, exp_cyc);
            else if (extra_at >= 0)
                check("R6 no restart", c, exp_cyc);
            else if (new_code_at >= 0)
                check("R10 code change ignored", c, exp_cyc);
            else
                check("R3 window length", c, exp_cyc);
            check("R8 irq at reset", int'(warn_irq), 1);
            repeat (2) @(negedge clk_lp);
            check("R9 rst held", int'(sys_rst_req), 1);
            check("R8 irq held", int'(warn_irq), 1);
        end
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);

        // R1: reset state and zero configuration
        do_reset();
        check("R1 irq after reset", int'(warn_irq), 0);
        check("R1 rst after reset", int'(sys_rst_req), 0);
        pulse(8'h04);
        check("R1 zero cfg direct rst", int'(sys_rst_req), 1);
        check("R1 zero cfg no irq", int'(warn_irq), 0);

        // R11: idle with no requests stays quiet
        do_reset();
        write_cfg(mk_cfg(8'hFF, 1'b1, 2'd0));
        repeat (20) @(negedge clk_lp);
        check("R11 idle irq", int'(warn_irq), 0);
        check("R11 idle rst", int'(sys_rst_req), 0);

        // R3 and R2: every delay code, each source bit in turn
        for (int k = 0; k < 4; k++)
            trial(mk_cfg(8'h01 << k, 1'b1, 2'(k)), 8'h01 << k, '0, -1, -1);
        for (int k = 4; k < 8; k++)
            trial(mk_cfg(8'h01 << k, 1'b1, 2'(k - 4)), 8'h01 << k, '0, -1, -1);

        // R5: global enable clear makes an enabled source direct
        trial(mk_cfg(8'hFF, 1'b0, 2'd1), 8'h10, '0, -1, -1);
        // R2: an enable on a different bit does not warn
        trial(mk_cfg(8'h02, 1'b1, 2'd0), 8'h01, '0, -1, -1);

        // R6: warned repeat request mid-window
        trial(mk_cfg(8'h0F, 1'b1, 2'd1), 8'h01, 8'h02, 10, -1);
        // R7: unwarned request mid-window, and on the last window cycle
        trial(mk_cfg(8'h0F, 1'b1, 2'd1), 8'h01, 8'h80, 5, -1);
        trial(mk_cfg(8'h0F, 1'b1, 2'd0), 8'h01, 8'h80, 7, -1);
        // R10: delay code rewritten during window
        trial(mk_cfg(8'hFF, 1'b1, 2'd0), 8'h20, '0, -1, 2);
        trial(mk_cfg(8'hFF, 1'b1, 2'd2), 8'h20, '0, -1, 50);

        // Constrained random trials
        for (int t = 0; t < 40; t++) begin
            logic [NSRC-1:0] en;
            logic [NSRC-1:0] req;
            logic [NSRC-1:0] extra;
            logic            g;
            logic [1:0]      code;
            int              at;
            int unsigned     sel;
            en   = NSRC'($urandom);
            g    = ($urandom % 4) != 0;
            code = 2'($urandom % 3);
            req  = (t % 2 == 0) ? (NSRC'($urandom) & en) : NSRC'($urandom);
            if (req == '0) req = (en != '0) ? (en & ~(en - 1'b1)) : 8'h01;
            sel = $urandom % 3;
            extra = (sel == 0) ? '0 : (sel == 1) ? (NSRC'($urandom) & en) : NSRC'($urandom);
            at = (extra == '0) ? -1 : int'($urandom % exp_len(code));
            trial(mk_cfg(en, g, code), req, extra, at, -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule